// File: doc/BRIEF.md
# Performance Counter Bank

This block holds six 32-bit event counters and two control registers for a processor core. On every clock it looks at how many instructions retired in that cycle and adds that number to each counter set to count instructions. Each counter set to count cycles gets one added. Event codes in the second control register pick the mode of counters 1 to 4. Counter 5 always counts instructions and counter 6 always counts cycles. Freeze bits in the first control register stop the whole bank, counters 1 to 4 as a group, or counters 5 and 6 as a group.

A counter with overflow detection enabled stops at the threshold 0x8000_0000, the value at which its top bit is set, and raises an overflow event. The event can freeze the whole bank, latch an alert flag and pulse an interrupt request for one cycle. Software reads and writes every counter and both control registers through a simple address/data port.

The request pulse comes from a two-state machine. ST_QUIET is the reset state, in which `irq_o` is low. Transition EVT_SEEN moves from ST_QUIET to ST_ALERT in any cycle with an overflow event. ST_ALERT drives `irq_o` high, stays in ST_ALERT on EVT_AGAIN when another event occurs in that cycle, and returns to ST_QUIET on EVT_NONE otherwise.

Top module: `pmu_counter_bank`

## Requirements
- R1: While reset is asserted, all six counters and both control registers read zero and `irq_o` is low.
- R2: When control register 0 (address 6) bit 0, the global freeze, is set, no counter changes unless software writes it.
- R3: Counters 1 to 4 take 8-bit event codes from control register 1 (address 7): counter 1 from bits 7:0, counter 2 from bits 15:8, counter 3 from bits 23:16 and counter 4 from bits 31:24.
  - Counter 1 counts instructions for code 0x02 or 0xFE and cycles for code 0x1E or 0xF0.
  - Counters 2 and 3 count instructions for code 0x02 and cycles for code 0x1E.
  - Every other code leaves the counter unchanged.
  - All four counters stop when control register 0 bit 1 is set or when control register 1 is zero.
- R4: Counter 4 counts cycles for code 0x1E and instructions for code 0x02. For code 0xFA it counts instructions only in cycles where `run_i` is high.
- R5: Counter 5 counts instructions and counter 6 counts cycles. Both stop only when control register 0 bit 0 or bit 2 is set.
- R6: In each cycle, an instruction-mode counter adds `ret_cnt_i`, which may be 0 up to its maximum, and a cycle-mode counter adds one.
- R7: Control register 0 bit 3 enables overflow detection for counter 1, and bit 4 enables it for counters 2 to 6.
  - When an enabled counter that advances in a cycle would reach or pass 0x8000_0000, it is set to exactly 0x8000_0000 and an overflow event occurs.
  - A counter without overflow detection keeps its full sum, wrapping modulo 2^32.
- R8: On an overflow event, if control register 0 bit 5 (freeze on event) is set, it is cleared and bit 0 is set. If bit 6 (alert enable) is set, it is cleared and bit 7 (alert seen) is set.
- R9: `irq_o` is high in the cycle after each cycle that has an overflow event, and low otherwise. Overflows in several counters in the same cycle give a single pulse.
- R10: Addresses 0 to 5 select counters 1 to 6, address 6 selects control register 0 and address 7 selects control register 1.
  - `reg_rdata_o` follows the address combinationally.
  - A write takes effect at the next clock edge. Counting in that cycle uses the old control values.
  - A write to a register wins over any update from counting or overflow in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0–5 counters, 6 control 0, 7 control 1) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| ret_cnt_i | input | RET_W (3) | Instructions retired this cycle |
| run_i | input | 1 | Run latch gating counter 4 under code 0xFA |
| irq_o | output | 1 | Single-cycle interrupt request |

## Verification
The bench targets the threshold edge with three cases:
- A counter that jumps past 0x8000_0000 by more than one must stop exactly on it. A design that only checks for equality, or that stores the raw sum, would read 0x8000_0001 or more.
- A counter with overflow detection disabled must not be clamped. This catches a design that ignores the enable bits or swaps the counter-1 bit with the shared bit.
- Two counters overflowing in the same cycle must give exactly one request cycle. A design that counts events instead of cycles would lengthen the pulse.

The bench also checks the following cases:
- A design that ignored the run gate would advance counter 4 under code 0xFA.
- A design that treated unknown codes as a mode would advance counter 4 under code 0x55.
- A design that misapplied a group freeze would advance a frozen counter.
- Freeze-on-event and alert-enable are each checked on their own, so that setting the wrong status bit is caught.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int NCNT = 6;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        CM_OFF  = 2'd0,
        CM_INSN = 2'd1,
        CM_CYC  = 2'd2
    } cnt_mode_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } irq_state_e;

    // control register 0 bit positions
    localparam int B_FRZ_ALL    = 0;
    localparam int B_FRZ_14     = 1;
    localparam int B_FRZ_56     = 2;
    localparam int B_OVF_EN1    = 3;
    localparam int B_OVF_ENX    = 4;
    localparam int B_FRZ_EVT    = 5;
    localparam int B_ALERT_EN   = 6;
    localparam int B_ALERT_SEEN = 7;

    // event codes
    localparam logic [CODE_W-1:0] EV_INSN     = 8'h02;
    localparam logic [CODE_W-1:0] EV_INSN_C1  = 8'hFE;
    localparam logic [CODE_W-1:0] EV_INSN_RUN = 8'hFA;
    localparam logic [CODE_W-1:0] EV_CYC      = 8'h1E;
    localparam logic [CODE_W-1:0] EV_CYC_C1   = 8'hF0;
endpackage

// File: rtl/pmu_mode_decode.sv
module pmu_mode_decode
    import pmu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] ctl0_i,
    input  logic [W-1:0] ctl1_i,
    input  logic         run_i,
    output cnt_mode_e    mode_o [NCNT],
    output logic         ovf_en_o [NCNT]
);
    localparam int NSEL = 4;

    logic grp14_on;
    logic grp56_on;

    assign grp14_on = !ctl0_i[B_FRZ_ALL] && !ctl0_i[B_FRZ_14] && (ctl1_i != '0);
    assign grp56_on = !ctl0_i[B_FRZ_ALL] && !ctl0_i[B_FRZ_56];

    function automatic cnt_mode_e classify(input int idx,
                                           input logic [CODE_W-1:0] code,
                                           input logic run);
        cnt_mode_e m;
        m = CM_OFF;
        if (code == EV_INSN) begin
            m = CM_INSN;
        end else if (code == EV_CYC) begin
            m = CM_CYC;
        end else if (idx == 0 && code == EV_INSN_C1) begin
            m = CM_INSN;
        end else if (idx == 0 && code == EV_CYC_C1) begin
            m = CM_CYC;
        end else if (idx == 3 && code == EV_INSN_RUN && run) begin
            m = CM_INSN;
        end
        return m;
    endfunction

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign mode_o[i] = grp14_on ? classify(i, ctl1_i[CODE_W*i +: CODE_W], run_i)
                                    : CM_OFF;
    end

    assign mode_o[4] = grp56_on ? CM_INSN : CM_OFF;
    assign mode_o[5] = grp56_on ? CM_CYC  : CM_OFF;

    for (genvar i = 0; i < NCNT; i++) begin : g_ovf
        if (i == 0) begin : g_first
            assign ovf_en_o[i] = ctl0_i[B_OVF_EN1];
        end else begin : g_rest
            assign ovf_en_o[i] = ctl0_i[B_OVF_ENX];
        end
    end
endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice
    import pmu_pkg::*;
#(
    parameter int W     = 32,
    parameter int RET_W = 3
) (
    input  cnt_mode_e        mode_i,
    input  logic [W-1:0]     cur_i,
    input  logic [RET_W-1:0] ret_i,
    input  logic             ovf_en_i,
    output logic [W-1:0]     nxt_o,
    output logic             ovf_o
);
    localparam logic [W:0] THR = (W+1)'(1) << (W-1);

    logic [W:0] inc;
    logic [W:0] sum;
    logic       active;

    always_comb begin
        unique case (mode_i)
            CM_INSN: inc = (W+1)'(ret_i);
            CM_CYC:  inc = (W+1)'(1);
            default: inc = '0;
        endcase
        active = (mode_i == CM_CYC) || (mode_i == CM_INSN && ret_i != '0);
        sum    = {1'b0, cur_i} + inc;
        ovf_o  = active && ovf_en_i && (sum >= THR);
        if (ovf_o) begin
            nxt_o = THR[W-1:0];
        end else if (active) begin
            nxt_o = sum[W-1:0];
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
    import pmu_pkg::*;
#(
    parameter int W     = 32,
    parameter int RET_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_we_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [W-1:0]     reg_wdata_i,
    output logic [W-1:0]     reg_rdata_o,
    input  logic [RET_W-1:0] ret_cnt_i,
    input  logic             run_i,
    output logic             irq_o
);
    localparam int AW = 3;
    localparam logic [AW-1:0] A_CTL0 = AW'(NCNT);
    localparam logic [AW-1:0] A_CTL1 = AW'(NCNT + 1);
    localparam logic [W-1:0]  THR    = W'(1) << (W-1);

    logic [W-1:0] cnt_q   [NCNT];
    logic [W-1:0] cnt_nxt [NCNT];
    logic         ovf_w   [NCNT];
    cnt_mode_e    mode_w  [NCNT];
    logic         ovf_en_w[NCNT];
    logic [W-1:0] ctl0_q, ctl0_d;
    logic [W-1:0] ctl1_q;
    logic         ovf_any;
    logic         ctl0_wr;
    irq_state_e   state_q, state_d;

    pmu_mode_decode #(.W(W)) i_decode (
        .ctl0_i  (ctl0_q),
        .ctl1_i  (ctl1_q),
        .run_i   (run_i),
        .mode_o  (mode_w),
        .ovf_en_o(ovf_en_w)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        pmu_counter_slice #(.W(W), .RET_W(RET_W)) i_slice (
            .mode_i  (mode_w[i]),
            .cur_i   (cnt_q[i]),
            .ret_i   (ret_cnt_i),
            .ovf_en_i(ovf_en_w[i]),
            .nxt_o   (cnt_nxt[i]),
            .ovf_o   (ovf_w[i])
        );

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                cnt_q[i] <= '0;
            end else if (reg_we_i && reg_addr_i == AW'(i)) begin
                cnt_q[i] <= reg_wdata_i;
            end else begin
                cnt_q[i] <= cnt_nxt[i];
            end
        end

        AST_FROZEN_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ctl0_q[B_FRZ_ALL] && !(reg_we_i && reg_addr_i == AW'(i)))
            |=> cnt_q[i] == $past(cnt_q[i])); // R2

        AST_CLAMP_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ovf_w[i] && !(reg_we_i && reg_addr_i == AW'(i)))
            |=> cnt_q[i] == THR); // R7

        if (i < 4) begin : g_grp
            AST_GROUP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (ctl0_q[B_FRZ_14] && !(reg_we_i && reg_addr_i == AW'(i)))
                |=> $stable(cnt_q[i])); // R3
        end
    end

    always_comb begin
        ovf_any = 1'b0;
        for (int i = 0; i < NCNT; i++) begin
            ovf_any = ovf_any | ovf_w[i];
        end
    end

    assign ctl0_wr = reg_we_i && reg_addr_i == A_CTL0;

    always_comb begin
        ctl0_d = ctl0_q;
        if (ovf_any) begin
            if (ctl0_q[B_FRZ_EVT]) begin
                ctl0_d[B_FRZ_EVT] = 1'b0;
                ctl0_d[B_FRZ_ALL] = 1'b1;
            end
            if (ctl0_q[B_ALERT_EN]) begin
                ctl0_d[B_ALERT_EN]   = 1'b0;
                ctl0_d[B_ALERT_SEEN] = 1'b1;
            end
        end
        if (ctl0_wr) begin
            ctl0_d = reg_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
        end else begin
            ctl0_q <= ctl0_d;
            if (reg_we_i && reg_addr_i == A_CTL1) begin
                ctl1_q <= reg_wdata_i;
            end
        end
    end

    AST_EVT_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_any && ctl0_q[B_FRZ_EVT] && !ctl0_wr)
        |=> (ctl0_q[B_FRZ_ALL] && !ctl0_q[B_FRZ_EVT])); // R8

    AST_ALERT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_any && ctl0_q[B_ALERT_EN] && !ctl0_wr)
        |=> (ctl0_q[B_ALERT_SEEN] && !ctl0_q[B_ALERT_EN])); // R8

    // request state machine: state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: state_d = ovf_any ? ST_ALERT : ST_QUIET;
            ST_ALERT: state_d = ovf_any ? ST_ALERT : ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // request state machine: outputs
    always_comb begin
        irq_o = (state_q == ST_ALERT);
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_any |=> irq_o); // R9

    AST_IRQ_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ovf_any |=> !irq_o); // R9

    always_comb begin
        unique case (reg_addr_i)
            A_CTL0:  reg_rdata_o = ctl0_q;
            A_CTL1:  reg_rdata_o = ctl1_q;
            default: reg_rdata_o = cnt_q[reg_addr_i];
        endcase
    end
endmodule

// File: tb/test_pmu_counter_bank.sv
`timescale 1ns/1ps
module test_pmu_counter_bank;
    localparam int W = 32;
    localparam int RET_W = 3;
    localparam logic [31:0] THR = 32'h8000_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [W-1:0]     reg_wdata = '0;
    logic [W-1:0]     reg_rdata;
    logic [RET_W-1:0] ret = '0;
    logic             run = 1'b0;
    logic             irq;

    pmu_counter_bank #(.W(W), .RET_W(RET_W)) i_pmu_counter_bank (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .reg_we_i   (reg_we),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .ret_cnt_i  (ret),
        .run_i      (run),
        .irq_o      (irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic        is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  mon_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(mon_ev);
            #0.1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d irq=%0b actual=%h expected=%h",
                             it.tag, it.addr, it.is_irq, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> mon_ev;
        #0.2;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        -> mon_ev;
        #0.2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic zero_all();
        for (int i = 0; i < 6; i++) wr(3'(i), 32'h0);
    endtask

    // n counting cycles with given retire count, then freeze again
    task automatic run_win(input int n, input logic [RET_W-1:0] r, input logic [31:0] base);
        wr(3'd6, base);
        ret = r;
        repeat (n - 1) @(negedge clk);
        wr(3'd6, base | 32'h1);
        ret = '0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) chk(3'(i), 32'h0, "R1 reset value");
        chk_irq(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        wr(3'd6, 32'h1);
        zero_all();

        // R2: global freeze
        ret = 3'd5;
        repeat (4) @(negedge clk);
        ret = '0;
        chk(3'd4, 32'h0, "R2 counter5 frozen");
        chk(3'd5, 32'h0, "R2 counter6 frozen");

        // R3 / R5 / R6: mixed modes
        wr(3'd7, 32'h001E_02FE);
        run_win(5, 3'd3, 32'h0);
        chk(3'd0, 32'd15, "R3 c1 code FE insn");
        chk(3'd1, 32'd15, "R3 c2 code 02 insn");
        chk(3'd2, 32'd5,  "R3 c3 code 1E cyc");
        chk(3'd3, 32'd0,  "R3 c4 code 00 off");
        chk(3'd4, 32'd15, "R5 c5 insn");
        chk(3'd5, 32'd5,  "R5 c6 cyc");

        zero_all();
        wr(3'd7, 32'h5502_1EF0);
        run_win(4, 3'd2, 32'h0);
        chk(3'd0, 32'd4, "R3 c1 code F0 cyc");
        chk(3'd1, 32'd4, "R3 c2 code 1E cyc");
        chk(3'd2, 32'd8, "R3 c3 code 02 insn");
        chk(3'd3, 32'd0, "R3 c4 code 55 ignored");

        // R3: group freeze 1-4
        zero_all();
        run_win(3, 3'd2, 32'h2);
        chk(3'd0, 32'd0, "R3 c1 group frozen");
        chk(3'd2, 32'd0, "R3 c3 group frozen");
        chk(3'd4, 32'd6, "R5 c5 runs in 1-4 freeze");
        chk(3'd5, 32'd3, "R5 c6 runs in 1-4 freeze");

        // R5: group freeze 5-6
        zero_all();
        wr(3'd7, 32'h0000_00F0);
        run_win(3, 3'd2, 32'h4);
        chk(3'd0, 32'd3, "R5 c1 runs in 5-6 freeze");
        chk(3'd4, 32'd0, "R5 c5 frozen");
        chk(3'd5, 32'd0, "R5 c6 frozen");

        // R4: run latch gating
        zero_all();
        wr(3'd7, 32'hFA00_0000);
        run = 1'b0;
        run_win(3, 3'd4, 32'h0);
        chk(3'd3, 32'd0, "R4 FA without run");
        run = 1'b1;
        run_win(3, 3'd4, 32'h0);
        chk(3'd3, 32'd12, "R4 FA with run");
        run = 1'b0;
        wr(3'd7, 32'h0200_0000);
        run_win(3, 3'd4, 32'h0);
        chk(3'd3, 32'd24, "R4 code 02 ignores run");
        wr(3'd7, 32'h1E00_0000);
        run_win(2, 3'd4, 32'h0);
        chk(3'd3, 32'd26, "R4 code 1E cyc");

        // R6: zero and maximum retire counts
        zero_all();
        wr(3'd7, 32'h0000_1E02);
        run_win(3, 3'd0, 32'h0);
        chk(3'd0, 32'd0, "R6 zero retired");
        chk(3'd1, 32'd3, "R6 cycles while zero retired");
        run_win(2, 3'd7, 32'h0);
        chk(3'd0, 32'd14, "R6 max retired");
        chk(3'd1, 32'd5,  "R6 cycles");

        // R7: disabled detection wraps, no clamp
        zero_all();
        wr(3'd2, 32'h7FFF_FFFE);
        wr(3'd7, 32'h0002_0000);
        run_win(1, 3'd3, 32'h0);
        chk(3'd2, 32'h8000_0001, "R7 no clamp when disabled");
        chk_irq(1'b0, "R9 no irq when disabled");

        // R7: shared bit does not cover counter 1
        wr(3'd0, 32'h7FFF_FFFF);
        wr(3'd7, 32'h0000_001E);
        run_win(2, 3'd0, 32'h10);
        chk(3'd0, 32'h8000_0001, "R7 c1 ignores shared enable");
        chk_irq(1'b0, "R9 no irq for c1 without own bit");

        // R7 / R8: counter 1 own bit, freeze on event
        wr(3'd0, 32'h7FFF_FFFF);
        wr(3'd6, 32'h28);
        @(negedge clk);
        chk(3'd0, THR, "R7 c1 clamp");
        chk(3'd6, 32'h09, "R8 freeze on event");
        chk_irq(1'b1, "R9 pulse");
        @(negedge clk);
        chk_irq(1'b0, "R9 pulse ends");
        chk(3'd0, THR, "R8 bank frozen after event");

        // R8: alert enable, overflow past threshold by more than one
        wr(3'd7, 32'h0000_0200);
        wr(3'd1, 32'h7FFF_FFFB);
        wr(3'd6, 32'h70);
        ret = 3'd2;
        repeat (2) @(negedge clk);
        chk(3'd1, 32'h7FFF_FFFF, "R7 below threshold");
        chk_irq(1'b0, "R9 quiet before event");
        @(negedge clk);
        ret = '0;
        chk(3'd1, THR, "R7 clamp on overshoot");
        chk(3'd6, 32'h91, "R8 alert seen and frozen");
        chk_irq(1'b1, "R9 pulse on alert");
        @(negedge clk);
        chk_irq(1'b0, "R9 single pulse");

        // R9: simultaneous overflows give one pulse
        wr(3'd7, 32'h0002_0200);
        wr(3'd1, 32'h7FFF_FFFF);
        wr(3'd2, 32'h7FFF_FFFE);
        wr(3'd6, 32'h30);
        ret = 3'd2;
        @(negedge clk);
        ret = '0;
        chk(3'd1, THR, "R9 c2 clamp");
        chk(3'd2, THR, "R9 c3 clamp");
        chk(3'd6, 32'h11, "R8 frozen no alert");
        chk_irq(1'b1, "R9 joint pulse");
        @(negedge clk);
        chk_irq(1'b0, "R9 joint pulse single cycle");

        // R10: write wins over counting, readback
        wr(3'd7, 32'h0000_001E);
        wr(3'd6, 32'h0);
        wr(3'd0, 32'd100);
        chk(3'd0, 32'd100, "R10 write wins over count");
        chk(3'd7, 32'h0000_001E, "R10 ctl1 readback");
        chk(3'd6, 32'h0, "R10 ctl0 readback");
        @(negedge clk);
        chk(3'd0, 32'd101, "R10 counting resumes");
        wr(3'd6, 32'h1);

        done = 1'b1;
        summary();
    end
endmodule